// File: doc/BRIEF.md
# SPI Master with Burst Select Hold

This block is a serial peripheral interface master that works through a small, programmable list of command entries. It runs one entry per transmitted word. Each entry sets the word length, the clock idle level and sampling phase, and which slave-select line to use. It also sets three delays, counted in whole serial-clock periods:

- a lead time from select assertion to the first clock edge;
- a trail time from the last clock edge to the select decision;
- a gap time that follows the trail time.

A keep flag in each entry decides what happens at the end of the trail time. With the flag clear, the select is released and the gap time passes before the next word may start. With the flag set, the select stays at its active level through the gap time. It then keeps holding until the next transmit word is accepted, so consecutive entries on the same line form one unbroken burst. If the next entry names another line, the held line is released first and the new one is asserted half a serial period later.

Transmit words enter through a valid/ready pair and are accepted only while the block waits between transfers. Each received word leaves on a one-cycle strobe. Every select output has its own polarity input, so a line can be active high or active low. The serial clock is the system clock divided by an even, programmable ratio.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, every select output is at its inactive level, `sclk` equals the clock-polarity bit of entry 0, and `tx_ready` is high.
- R2: Each `cmd_cfg` entry is 18 bits wide, and entry i occupies bits [18i+17:18i]. The fields within an entry are:
  - bits [3:0]: word length minus one;
  - bit 4: clock polarity;
  - bit 5: clock phase;
  - bits [7:6]: select index;
  - bits [10:8]: lead delay minus one;
  - bits [13:11]: trail delay minus one;
  - bits [16:14]: gap delay minus one;
  - bit 17: keep flag.

  Entries run in order 0, 1, … up to `cmd_last`, then wrap to 0.
- R3: One serial period is 2·(`div_half`+1) system clocks. The first `sclk` edge of a word comes exactly lead-delay periods after the select asserts. Edges then follow every half period.
- R4: A word of length n gives 2n `sclk` edges and is sent MSB first (bit n−1 first).
  - With phase 0, `mosi` is valid before the first edge, input is sampled on leading edges, and `mosi` changes on trailing edges.
  - With phase 1, `mosi` changes on leading edges and input is sampled on trailing edges.
- R5: `rx_valid` is high for exactly one cycle, starting at the last `sclk` edge. `rx_data` then holds the n sampled bits right-aligned, with the first sampled bit as the MSB and zeros above.
- R6: The select stays active for exactly trail-delay periods after the last `sclk` edge.
- R7: With the keep flag 0, the select goes inactive when the trail delay ends. `tx_ready` returns gap-delay periods later.
- R8: With the keep flag 1, the select stays active through the gap delay and then until the next word is accepted. If that word's entry uses the same line, the line never goes inactive.
- R9: If a held line differs from the next entry's line, the held line goes inactive at the accept edge. The new line asserts (`div_half`+1) cycles later, and its lead delay counts from that point. At most one select is ever active.
- R10: Select output i is active when it equals `sel_pol[i]`, and inactive at the opposite level.
- R11: `tx_ready` is high only while waiting between transfers, and a word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_half | input | 8 | Half serial period in system clocks, minus one |
| cmd_last | input | 2 | Index of the last entry in the command list |
| cmd_cfg | input | 72 | Four packed command entries, 18 bits each |
| sel_pol | input | 4 | Active level of each select line |
| tx_data | input | 16 | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Block can accept a transmit word |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_o | output | 4 | Slave-select outputs |

## Verification
The bench builds the block with its defaults: four select lines, 16-bit words, four entries and an 8-bit divider with 3-bit delays. Three command lists are run with divider values 0, 1 and 2. Together they cover:

- single-bit and full 16-bit words;
- both clock polarities and both phases, including a polarity change while a select is held;
- the largest delay of 8 periods;
- a burst on one line, a release, and a swap from one held line to another;
- a hold stretched by late transmit data.

The same bench also covers mixed active-high and active-low lines, and an inverted loopback on `miso` that makes received data differ from transmitted data.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_SWAP,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_HOLD,
    ST_GAP
  } seq_state_t;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  // One tick per half serial period while a transfer sequence is running.
  assign tick = run && (cnt_q == div_half);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // R3: the half-period counter never runs past its programmed limit.
  assert_tick_bound_R3: assert property (@(posedge clk) disable iff (rst)
    ($stable(div_half) && run) |-> (cnt_q <= div_half));

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int WORD_W = 16,
  parameter int LEN_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              cpha,
  input  logic              edge_en,
  input  logic              lead_edge,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_final
);

  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic [WORD_W-1:0] aligned;
  logic              sample_now;

  // Place the word's top bit at the register MSB so shifting left sends MSB first.
  assign aligned    = tx_word << (WORD_W - 1 - int'(len_m1));
  assign sample_now = lead_edge ^ cpha;
  assign rx_final   = sample_now ? {rx_q[WORD_W-2:0], miso} : rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
      mosi <= 1'b0;
    end else if (load) begin
      tx_q <= aligned;
      rx_q <= '0;
      mosi <= aligned[WORD_W-1];
    end else if (edge_en) begin
      if (sample_now) begin
        rx_q <= {rx_q[WORD_W-2:0], miso};
      end else if (cpha) begin
        mosi <= tx_q[WORD_W-1];
        tx_q <= tx_q << 1;
      end else begin
        mosi <= tx_q[WORD_W-2];
        tx_q <= tx_q << 1;
      end
    end
  end

  // R4: no data movement is possible on a cycle that both loads and clocks.
  assert_no_load_edge_R4: assert property (@(posedge clk) disable iff (rst)
    !(load && edge_en));

endmodule

// File: rtl/spi_sel_drive.sv
module spi_sel_drive #(
  parameter int SEL_N = 4,
  parameter int SEL_W = $clog2(SEL_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [SEL_W-1:0] set_idx,
  input  logic             clr,
  input  logic [SEL_N-1:0] sel_pol,
  output logic [SEL_N-1:0] act,
  output logic [SEL_N-1:0] sel_o
);

  logic [SEL_N-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      act_q <= '0;
    end else if (set_en) begin
      act_q <= SEL_N'(1) << set_idx;
    end
  end

  assign act = act_q;

  // Active line shows its polarity bit, the rest show the opposite level.
  assign sel_o = ~(act_q ^ sel_pol);

  // R9: never two lines active together.
  assert_onehot_sel_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act_q));

  // R7: a release request leaves every line inactive on the next cycle.
  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (act_q == '0));

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter  int SEL_N  = 4,
  parameter  int WORD_W = 16,
  parameter  int CMD_N  = 4,
  parameter  int DIV_W  = 8,
  parameter  int DLY_W  = 3,
  localparam int LEN_W  = $clog2(WORD_W),
  localparam int SEL_W  = $clog2(SEL_N),
  localparam int PTR_W  = $clog2(CMD_N),
  localparam int F_CPOL = LEN_W,
  localparam int F_CPHA = LEN_W + 1,
  localparam int F_SEL  = LEN_W + 2,
  localparam int F_LEAD = F_SEL + SEL_W,
  localparam int F_TRL  = F_LEAD + DLY_W,
  localparam int F_GAP  = F_TRL + DLY_W,
  localparam int F_KEEP = F_GAP + DLY_W,
  localparam int CMD_W  = F_KEEP + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DIV_W-1:0]       div_half,
  input  logic [PTR_W-1:0]       cmd_last,
  input  logic [CMD_N*CMD_W-1:0] cmd_cfg,
  input  logic [SEL_N-1:0]       sel_pol,
  input  logic [WORD_W-1:0]      tx_data,
  input  logic                   tx_valid,
  output logic                   tx_ready,
  output logic [WORD_W-1:0]      rx_data,
  output logic                   rx_valid,
  output logic                   sclk,
  output logic                   mosi,
  input  logic                   miso,
  output logic [SEL_N-1:0]       sel_o
);

  localparam int MAXT  = (2 * WORD_W > (2 << DLY_W)) ? 2 * WORD_W : (2 << DLY_W);
  localparam int CNT_W = $clog2(MAXT);

  // Unpacked command fields.
  logic [LEN_W-1:0] e_len  [CMD_N];
  logic             e_cpol [CMD_N];
  logic             e_cpha [CMD_N];
  logic [SEL_W-1:0] e_sel  [CMD_N];
  logic [DLY_W-1:0] e_lead [CMD_N];
  logic [DLY_W-1:0] e_trl  [CMD_N];
  logic [DLY_W-1:0] e_gap  [CMD_N];
  logic             e_keep [CMD_N];

  for (genvar gi = 0; gi < CMD_N; gi++) begin : g_entry
    localparam int B = gi * CMD_W;
    assign e_len[gi]  = cmd_cfg[B +: LEN_W];
    assign e_cpol[gi] = cmd_cfg[B + F_CPOL];
    assign e_cpha[gi] = cmd_cfg[B + F_CPHA];
    assign e_sel[gi]  = cmd_cfg[B + F_SEL +: SEL_W];
    assign e_lead[gi] = cmd_cfg[B + F_LEAD +: DLY_W];
    assign e_trl[gi]  = cmd_cfg[B + F_TRL +: DLY_W];
    assign e_gap[gi]  = cmd_cfg[B + F_GAP +: DLY_W];
    assign e_keep[gi] = cmd_cfg[B + F_KEEP];
  end

  seq_state_t        state_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_nx;
  logic [CNT_W-1:0]  dcnt_q;
  logic              sclk_q;
  logic              rxv_q;
  logic [WORD_W-1:0] rxd_q;
  logic              tick;
  logic              accept;
  logic              swap_need;
  logic              dly_done;
  logic              edge_en;
  logic              lead_edge;
  logic              sel_set;
  logic              sel_clr;
  logic [SEL_N-1:0]  act;
  logic [WORD_W-1:0] rx_final;

  assign ptr_nx    = (ptr_q >= cmd_last) ? '0 : ptr_q + PTR_W'(1);
  assign tx_ready  = (state_q == ST_WAIT);
  assign accept    = tx_ready && tx_valid;
  assign swap_need = (|act) && !act[e_sel[ptr_q]];
  assign dly_done  = tick && (dcnt_q == '0);
  assign edge_en   = (state_q == ST_SHIFT) && tick;
  assign lead_edge = (sclk_q == e_cpol[ptr_q]);
  assign sel_set   = (accept && !swap_need) || ((state_q == ST_SWAP) && tick);
  assign sel_clr   = (accept && swap_need) ||
                     ((state_q == ST_TRAIL) && dly_done && !e_keep[ptr_q]);

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .run      (state_q != ST_WAIT),
    .div_half (div_half),
    .tick     (tick)
  );

  spi_shift_unit #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .tx_word   (tx_data),
    .len_m1    (e_len[ptr_q]),
    .cpha      (e_cpha[ptr_q]),
    .edge_en   (edge_en),
    .lead_edge (lead_edge),
    .miso      (miso),
    .mosi      (mosi),
    .rx_final  (rx_final)
  );

  spi_sel_drive #(.SEL_N(SEL_N), .SEL_W(SEL_W)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .set_en  (sel_set),
    .set_idx (e_sel[ptr_q]),
    .clr     (sel_clr),
    .sel_pol (sel_pol),
    .act     (act),
    .sel_o   (sel_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      ptr_q   <= '0;
      dcnt_q  <= '0;
      sclk_q  <= e_cpol[0];
      rxv_q   <= 1'b0;
      rxd_q   <= '0;
    end else begin
      rxv_q <= 1'b0;
      unique case (state_q)
        ST_WAIT: begin
          sclk_q <= e_cpol[ptr_q];
          if (tx_valid) begin
            dcnt_q  <= CNT_W'(e_lead[ptr_q]) << 1;
            state_q <= swap_need ? ST_SWAP : ST_LEAD;
          end
        end
        ST_SWAP: begin
          if (tick) begin
            state_q <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (dly_done) begin
            dcnt_q  <= (CNT_W'(e_len[ptr_q]) << 1) + CNT_W'(1);
            state_q <= ST_SHIFT;
          end else if (tick) begin
            dcnt_q <= dcnt_q - CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
          end
          if (dly_done) begin
            rxv_q   <= 1'b1;
            rxd_q   <= rx_final;
            dcnt_q  <= (CNT_W'(e_trl[ptr_q]) << 1) + CNT_W'(1);
            state_q <= ST_TRAIL;
          end else if (tick) begin
            dcnt_q <= dcnt_q - CNT_W'(1);
          end
        end
        ST_TRAIL: begin
          if (dly_done) begin
            dcnt_q  <= (CNT_W'(e_gap[ptr_q]) << 1) + CNT_W'(1);
            state_q <= e_keep[ptr_q] ? ST_HOLD : ST_GAP;
          end else if (tick) begin
            dcnt_q <= dcnt_q - CNT_W'(1);
          end
        end
        ST_HOLD, ST_GAP: begin
          if (dly_done) begin
            ptr_q   <= ptr_nx;
            sclk_q  <= e_cpol[ptr_nx];
            state_q <= ST_WAIT;
          end else if (tick) begin
            dcnt_q <= dcnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  assign sclk     = sclk_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

  // R3: serial clock is quiet during the lead, trail and swap windows.
  assert_sclk_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LEAD || state_q == ST_TRAIL || state_q == ST_SWAP) |=> $stable(sclk_q));

  // R5: the receive strobe lasts a single cycle.
  assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8: the select is not touched while the minimum hold runs.
  assert_hold_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |=> $stable(act));

  // R11: an accepted word closes the ready window at once.
  assert_ready_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

endmodule

// File: tb/test_spi_burst_master.sv
module test_spi_burst_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  div_half = 8'd1;
  logic [1:0]  cmd_last = 2'd0;
  logic [71:0] cmd_cfg = '0;
  logic [3:0]  sel_pol = 4'b0000;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] rx_data;
  logic        rx_valid;
  logic        sclk;
  logic        mosi;
  logic        miso;
  logic [3:0]  sel_o;
  logic        inv = 1'b0;

  always #4 clk = ~clk;

  assign miso = mosi ^ inv;

  spi_burst_master i_spi_burst_master (
    .clk(clk), .rst(rst), .div_half(div_half), .cmd_last(cmd_last),
    .cmd_cfg(cmd_cfg), .sel_pol(sel_pol), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi), .miso(miso), .sel_o(sel_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  int e_len[4], e_cpol[4], e_cpha[4], e_sel[4], e_lead[4], e_trl[4], e_gap[4], e_keep[4];
  logic [15:0] words[8];
  int gaps[8];

  logic [3:0]  exp_act;
  logic        exp_sclk, exp_ready, exp_rxv;
  logic [15:0] exp_rx;
  string       tag = "R1";
  bit          chk_on = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act_v, exp_v);
    end
  endtask

  task automatic set_entry(input int i, input int len, input int cpol, input int cpha,
                           input int sel, input int lead, input int trl, input int gap, input int keep);
    e_len[i] = len; e_cpol[i] = cpol; e_cpha[i] = cpha; e_sel[i] = sel;
    e_lead[i] = lead; e_trl[i] = trl; e_gap[i] = gap; e_keep[i] = keep;
    cmd_cfg[i*18 +: 18] = {keep[0], 3'(gap - 1), 3'(trl - 1), 3'(lead - 1),
                           2'(sel), cpha[0], cpol[0], 4'(len - 1)};
  endtask

  // Per-cycle comparison against the behavioural timeline.
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      check(sel_o === ~(exp_act ^ sel_pol), {tag, " R10 select"}, 32'(sel_o), 32'(~(exp_act ^ sel_pol)));
      check(sclk === exp_sclk, {tag, " sclk"}, 32'(sclk), 32'(exp_sclk));
      check(tx_ready === exp_ready, "R11 tx_ready", 32'(tx_ready), 32'(exp_ready));
      check(rx_valid === exp_rxv, "R5 rx_valid", 32'(rx_valid), 32'(exp_rxv));
      if (exp_rxv) check(rx_data === exp_rx, "R5 rx_data", 32'(rx_data), 32'(exp_rx));
    end
  end

  task automatic driver(input int nw);
    for (int w = 0; w < nw; w++) begin
      repeat (gaps[w]) @(negedge clk);
      tx_data  = words[w];
      tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
    end
  endtask

  task automatic model(input int nw);
    int p;
    int dh;
    int mask;
    logic [15:0] cap;
    p = 0;
    dh = int'(div_half) + 1;
    for (int w = 0; w < nw; w++) begin
      tag = "R2";
      do @(posedge clk); while (tx_valid !== 1'b1);
      exp_ready = 1'b0;
      if (exp_act != 4'b0 && !exp_act[e_sel[p]]) begin
        tag = "R9";
        exp_act = 4'b0;
        repeat (dh) @(posedge clk);
      end
      exp_act = 4'b1 << e_sel[p];
      tag = "R3";
      mask = (1 << e_len[p]) - 1;
      cap = '0;
      repeat (2 * e_lead[p] * dh) @(posedge clk);
      tag = "R4";
      for (int k = 0; k < 2 * e_len[p]; k++) begin
        bit lead_e;
        if (k > 0) repeat (dh) @(posedge clk);
        lead_e = (exp_sclk == e_cpol[p][0]);
        exp_sclk = ~exp_sclk;
        if (k == 2 * e_len[p] - 1) begin
          exp_rxv = 1'b1;
          exp_rx  = 16'((int'(words[w]) ^ (inv ? mask : 0)) & mask);
        end
        if (lead_e != e_cpha[p][0]) begin
          @(negedge clk);
          cap = {cap[14:0], mosi};
        end
      end
      check(cap == 16'(int'(words[w]) & mask), "R4 mosi bit order", 32'(cap), 32'(int'(words[w]) & mask));
      tag = "R6";
      @(posedge clk);
      exp_rxv = 1'b0;
      repeat (2 * e_trl[p] * dh - 1) @(posedge clk);
      if (e_keep[p] != 0) begin
        tag = "R8";
      end else begin
        tag = "R7";
        exp_act = 4'b0;
      end
      repeat (2 * e_gap[p] * dh) @(posedge clk);
      p = (p >= int'(cmd_last)) ? 0 : p + 1;
      exp_ready = 1'b1;
      exp_sclk = e_cpol[p][0];
    end
  endtask

  task automatic start_scenario(input int nw);
    chk_on = 1'b0;
    rst = 1'b1;
    tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(sel_o === ~sel_pol, "R1 idle selects", 32'(sel_o), 32'(~sel_pol));
    check(sel_o === ~sel_pol, "R10 inactive level per line", 32'(sel_o), 32'(~sel_pol));
    check(sclk === e_cpol[0][0], "R1 idle sclk", 32'(sclk), 32'(e_cpol[0]));
    check(tx_ready === 1'b1, "R1 ready after reset", 32'(tx_ready), 32'd1);
    exp_act = 4'b0; exp_sclk = e_cpol[0][0]; exp_ready = 1'b1; exp_rxv = 1'b0; exp_rx = '0;
    chk_on = 1'b1;
    fork
      driver(nw);
      model(nw);
    join
  endtask

  task automatic run_all();
    // Burst on one line, release, then hold with a swap to another line.
    div_half = 8'd1; sel_pol = 4'b0101; inv = 1'b0; cmd_last = 2'd2;
    set_entry(0, 8, 0, 0, 0, 1, 2, 3, 1);
    set_entry(1, 8, 0, 1, 0, 2, 1, 1, 0);
    set_entry(2, 12, 0, 0, 2, 3, 1, 2, 1);
    words[0] = 16'h00a5; words[1] = 16'h003c; words[2] = 16'h0e71;
    words[3] = 16'h0081; words[4] = 16'h00fe; words[5] = 16'h0123; words[6] = 16'h0047;
    gaps[0] = 1; gaps[1] = 40; gaps[2] = 0; gaps[3] = 3; gaps[4] = 0; gaps[5] = 5; gaps[6] = 2;
    start_scenario(7);
    // Full-length words, maximal delays, fastest clock, inverted loopback.
    div_half = 8'd0; sel_pol = 4'b0000; inv = 1'b1; cmd_last = 2'd0;
    set_entry(0, 16, 1, 1, 3, 8, 8, 1, 1);
    words[0] = 16'hbeef; words[1] = 16'h1234; words[2] = 16'h8001;
    gaps[0] = 0; gaps[1] = 0; gaps[2] = 10;
    start_scenario(3);
    // Single-bit word, polarity change while a select is held.
    div_half = 8'd2; sel_pol = 4'b1111; inv = 1'b0; cmd_last = 2'd1;
    set_entry(0, 1, 1, 0, 1, 1, 1, 1, 0);
    set_entry(1, 16, 0, 1, 1, 1, 1, 2, 1);
    words[0] = 16'h0001; words[1] = 16'hc3a5; words[2] = 16'h0000; words[3] = 16'h7ffe;
    gaps[0] = 2; gaps[1] = 0; gaps[2] = 6; gaps[3] = 1;
    start_scenario(4);
    chk_on = 1'b0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule